// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block is a single-direction FIFO of 36-bit words placed between two free-running clocks. The two clocks may be unrelated or may be the same clock. The producer writes on the write clock and the consumer reads on the read clock. The depth is a parameter: 256, 512 or 1024 words. Each side builds its own status flags from registers in its own clock domain. Pointers cross between the domains as Gray code through two-flop synchronizers, so a flag can lag the far side by a few cycles. The lag is always in the safe direction: the write side may report less space than there is, and the read side may report fewer words than there are.

Two flag conventions can be chosen, and the choice is made while reset is held. In standard timing the write-side flag means "full" and the read-side flag means "empty", and a read loads the next word into the output register one clock later. In fall-through timing the write-side flag means "ready for input" and the read-side flag means "output holds a valid word". The oldest word is presented on the output without any request, and a read acknowledges it and consumes it. The almost-full and almost-empty thresholds are taken from offset inputs during reset. A bidirectional buffer is built from two instances placed in opposite directions.

Top module: `dcf_fifo`

## Requirements
- R1: Every accepted word leaves in write order, with no loss and no duplication. This holds with the two clocks tied together and with the two clocks at unrelated periods.
- R2: While `rst_n` is low for at least three cycles of each clock, both pointers and the read data register are cleared. Standard timing then shows `wr_flag`=0, `rd_flag`=1 and `rd_almost_empty`=1. Fall-through timing shows `wr_flag`=1 and `rd_flag`=0.
- R3: In standard timing (`cfg_fwft`=0), `wr_flag`=1 exactly when DEPTH words are stored, and `rd_flag`=1 exactly when no word is stored. A read with `rd_en`=1 while not empty updates `rd_data` on that read-clock edge.
- R4: In fall-through timing (`cfg_fwft`=1), the oldest word appears on `rd_data` with `rd_flag`=1 without any read. `rd_flag` falls only after a read with `rd_en`=1. `wr_flag`=1 while the storage array holds fewer than DEPTH words. The output register adds one word, so the total capacity is DEPTH+1.
- R5: A write while the array is full is ignored, and the word never appears at the output. A read while no word is available is ignored: the read pointer, and in standard timing `rd_data`, stay unchanged.
- R6: Once settled, `rd_almost_empty`=1 exactly when the stored word count is at or below the almost-empty offset. In fall-through timing the count includes the word held on the output.
- R7: Once settled, `wr_almost_full`=1 exactly when DEPTH minus the number of words in the storage array is at or below the almost-full offset.
- R8: A read and a write on the same clock edge both take effect, and the word count stays unchanged.
- R9: `cfg_fwft`, `cfg_af_off` and `cfg_ae_off` are captured only while `rst_n` is low. Changes after reset have no effect until the next reset.
- R10: Each Gray pointer changes at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| cfg_fwft | input | 1 | Timing select captured in reset: 0 standard, 1 fall-through |
| cfg_af_off | input | $clog2(DEPTH)+1 | Almost-full offset captured in reset |
| cfg_ae_off | input | $clog2(DEPTH)+1 | Almost-empty offset captured in reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| wr_almost_full | output | 1 | Free space at or below the almost-full offset |
| rd_en | input | 1 | Read request or acknowledge |
| rd_data | output | WIDTH | Output word register |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| rd_almost_empty | output | 1 | Word count at or below the almost-empty offset |

## Verification
The bench walks the fill level through every value from empty to full and back in both timing modes, checking every flag at each level. This catches off-by-one errors in the threshold compares, and the extra output-register word in fall-through timing, which a wrong design would count twice or not at all. Writes at full and reads at empty are followed by a full drain. A design that moved a pointer anyway would then emit a stale or extra word, or skip one. Same-edge read and write streams, and offsets changed after reset, expose a design that drops one of two concurrent operations or keeps tracking the live configuration inputs. Long streams with unrelated clock periods then expose a pointer crossing that tears, which shows up as corrupt or repeated data.

// File: rtl/dcf_pkg.sv
// Shared constants and types for the dual-clock FIFO.
// Assumes nothing beyond a SystemVerilog 2017 compiler.
package dcf_pkg;
    localparam int unsigned WORD_W = 36;

    // Flag convention selected while reset is held.
    typedef enum logic {
        TM_STD  = 1'b0,
        TM_FWFT = 1'b1
    } timing_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes the input changes at most one bit per source clock edge.
module dcf_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages in the destination clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
// Storage array: one write port on the write clock, and one registered read
// port on the read clock. Assumes that the control logic never reads an
// entry while it is being written.
module dcf_ram #(
    parameter int W  = 36,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store the accepted word.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Load the output register on a read; clear it while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-side control: write pointer, its Gray copy, and the full and
// almost-full flags, all in the write clock domain.
// Assumes rst_n is held low for at least three write clock cycles.
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic [AW:0]   cfg_af_off,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_async,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wbin,
    output logic          we,
    output logic          full,
    output logic          wr_flag,
    output logic          almost_full,
    output logic          mode_fwft
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(1 << AW);

    timing_mode_e  mode_q;
    logic [PW-1:0] off_q;
    logic [PW-1:0] rgray_s;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;
    logic [PW-1:0] wnext;

    // Convert a Gray pointer to binary.
    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    dcf_sync #(.W(PW)) u_rsync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rgray_async),
        .q    (rgray_s)
    );

    // Occupancy of the array as seen from the write side.
    always_comb begin
        rbin_s      = gray2bin(rgray_s);
        wcount      = wbin - rbin_s;
        full        = (wcount == DEPTH_P);
        we          = wr_en && !full;
        wnext       = wbin + PW'(we);
        almost_full = (DEPTH_P - wcount) <= off_q;
        wr_flag     = (mode_q == TM_FWFT) ? !full : full;
    end

    // Advance the pointer on an accepted write; capture the configuration in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            mode_q <= cfg_fwft ? TM_FWFT : TM_STD;
            off_q  <= cfg_af_off;
        end else begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    assign waddr     = wbin[AW-1:0];
    assign mode_fwft = (mode_q == TM_FWFT);
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-side control: read pointer, the valid state of the output register in
// fall-through timing, and the empty/ready and almost-empty flags, all in
// the read clock domain.
// Assumes rst_n is held low for at least three read clock cycles.
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic [AW:0]   cfg_ae_off,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_async,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [AW:0]   rbin,
    output logic          load,
    output logic          empty_mem,
    output logic          rd_flag,
    output logic          almost_empty,
    output logic          mode_fwft
);
    localparam int PW = AW + 1;

    timing_mode_e  mode_q;
    logic [PW-1:0] off_q;
    logic          valid_q;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic [PW-1:0] rnext;

    // Convert a Gray pointer to binary.
    function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    dcf_sync #(.W(PW)) u_wsync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (wgray_async),
        .q    (wgray_s)
    );

    // Decide whether the array is popped this cycle and derive the flags.
    always_comb begin
        wbin_s    = gray2bin(wgray_s);
        empty_mem = (rbin == wbin_s);
        if (mode_q == TM_FWFT) load = !empty_mem && (!valid_q || rd_en);
        else                   load = rd_en && !empty_mem;
        rnext        = rbin + PW'(load);
        rcount       = (wbin_s - rbin) + PW'((mode_q == TM_FWFT) && valid_q);
        almost_empty = rcount <= off_q;
        rd_flag      = (mode_q == TM_FWFT) ? valid_q : empty_mem;
    end

    // Advance the pointer and the output valid state; capture the configuration in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            valid_q <= 1'b0;
            mode_q  <= cfg_fwft ? TM_FWFT : TM_STD;
            off_q   <= cfg_ae_off;
        end else begin
            rbin  <= rnext;
            rgray <= rnext ^ (rnext >> 1);
            if (load)       valid_q <= 1'b1;
            else if (rd_en) valid_q <= 1'b0;
        end
    end

    assign raddr     = rbin[AW-1:0];
    assign mode_fwft = (mode_q == TM_FWFT);
endmodule

// File: rtl/dcf_fifo.sv
// Dual-clock FIFO top. It ties the write control, the read control and the
// storage array together. DEPTH must be 256, 512 or 1024.
// Assumes one rst_n that both clocks sample, held low for at least
// three cycles of each clock.
module dcf_fifo #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = dcf_pkg::WORD_W
) (
    input  logic                   wclk,
    input  logic                   rclk,
    input  logic                   rst_n,
    input  logic                   cfg_fwft,
    input  logic [$clog2(DEPTH):0] cfg_af_off,
    input  logic [$clog2(DEPTH):0] cfg_ae_off,
    input  logic                   wr_en,
    input  logic [WIDTH-1:0]       wr_data,
    output logic                   wr_flag,
    output logic                   wr_almost_full,
    input  logic                   rd_en,
    output logic [WIDTH-1:0]       rd_data,
    output logic                   rd_flag,
    output logic                   rd_almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] w_gray;
    logic [PW-1:0] r_gray;
    logic [PW-1:0] w_bin;
    logic [PW-1:0] r_bin;
    logic          w_we;
    logic          w_full;
    logic          r_load;
    logic          r_empty;
    logic          w_mode;
    logic          r_mode;

    dcf_wr_ctl #(.AW(AW)) u_wr (
        .clk        (wclk),
        .rst_n      (rst_n),
        .cfg_fwft   (cfg_fwft),
        .cfg_af_off (cfg_af_off),
        .wr_en      (wr_en),
        .rgray_async(r_gray),
        .waddr      (waddr),
        .wgray      (w_gray),
        .wbin       (w_bin),
        .we         (w_we),
        .full       (w_full),
        .wr_flag    (wr_flag),
        .almost_full(wr_almost_full),
        .mode_fwft  (w_mode)
    );

    dcf_rd_ctl #(.AW(AW)) u_rd (
        .clk         (rclk),
        .rst_n       (rst_n),
        .cfg_fwft    (cfg_fwft),
        .cfg_ae_off  (cfg_ae_off),
        .rd_en       (rd_en),
        .wgray_async (w_gray),
        .raddr       (raddr),
        .rgray       (r_gray),
        .rbin        (r_bin),
        .load        (r_load),
        .empty_mem   (r_empty),
        .rd_flag     (rd_flag),
        .almost_empty(rd_almost_empty),
        .mode_fwft   (r_mode)
    );

    dcf_ram #(.W(WIDTH), .AW(AW)) u_ram (
        .wclk (wclk),
        .we   (w_we),
        .waddr(waddr),
        .wdata(wr_data),
        .rclk (rclk),
        .rst_n(rst_n),
        .re   (r_load),
        .raddr(raddr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/dcf_fifo_chk.sv
// Property checker for dcf_fifo, attached to it by the bind below.
// Assumes the same reset conditions as the block it observes.
module dcf_fifo_chk #(
    parameter int AW = 10
) (
    input logic        wclk,
    input logic        rclk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic        rd_flag,
    input logic        wr_almost_full,
    input logic        rd_almost_empty,
    input logic        w_full,
    input logic        r_empty,
    input logic        r_mode,
    input logic [AW:0] w_bin,
    input logic [AW:0] r_bin,
    input logic [AW:0] w_gray,
    input logic [AW:0] r_gray
);
    // R5: a write at full leaves the write pointer where it was.
    a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
        (w_full && wr_en) |=> $stable(w_bin));

    // R5: with nothing stored, the read pointer does not move.
    a_r5_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
        r_empty |=> $stable(r_bin));

    // R10: the write Gray pointer moves by at most one bit.
    a_r10_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1);

    // R10: the read Gray pointer moves by at most one bit.
    a_r10_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1);

    // R7: full implies almost full.
    a_r7_full_is_almost: assert property (@(posedge wclk) disable iff (!rst_n)
        w_full |-> wr_almost_full);

    // R6: standard empty implies almost empty.
    a_r6_empty_is_almost: assert property (@(posedge rclk) disable iff (!rst_n)
        (!r_mode && rd_flag) |-> rd_almost_empty);

    // R4: output ready drops only after an acknowledging read.
    a_r4_ready_held: assert property (@(posedge rclk) disable iff (!rst_n)
        (r_mode && $fell(rd_flag)) |-> $past(rd_en));
endmodule

bind dcf_fifo dcf_fifo_chk #(.AW($clog2(DEPTH))) u_chk (
    .wclk           (wclk),
    .rclk           (rclk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .rd_en          (rd_en),
    .rd_flag        (rd_flag),
    .wr_almost_full (wr_almost_full),
    .rd_almost_empty(rd_almost_empty),
    .w_full         (w_full),
    .r_empty        (r_empty),
    .r_mode         (r_mode),
    .w_bin          (w_bin),
    .r_bin          (r_bin),
    .w_gray         (w_gray),
    .r_gray         (r_gray)
);

// File: tb/tb_dcf_fifo.sv
// Bench for dcf_fifo at DEPTH 256: fill/drain sweeps on a shared clock, then streams on unrelated clocks.
module tb_dcf_fifo;
    localparam int D  = 256;
    localparam int W  = 36;
    localparam int PW = 9;
    localparam int NSTREAM = 600;

    logic wclk = 1'b0;
    logic clkb = 1'b0;
    logic use_async = 1'b0;
    logic rclk;
    logic rst_n = 1'b0;
    logic cfg_fwft = 1'b0;
    logic [PW-1:0] cfg_af_off = '0;
    logic [PW-1:0] cfg_ae_off = '0;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic wr_flag, wr_almost_full, rd_flag, rd_almost_empty;
    logic [W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit fwft_m = 1'b0;
    int af_m = 0;
    int ae_m = 0;

    always #10 wclk = ~wclk;
    always #7  clkb = ~clkb;
    assign rclk = use_async ? clkb : wclk;

    dcf_fifo #(.DEPTH(D), .WIDTH(W)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_fwft(cfg_fwft),
        .cfg_af_off(cfg_af_off), .cfg_ae_off(cfg_ae_off),
        .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
        .wr_almost_full(wr_almost_full), .rd_en(rd_en), .rd_data(rd_data),
        .rd_flag(rd_flag), .rd_almost_empty(rd_almost_empty)
    );

    function automatic logic [W-1:0] word(input int n);
        logic [31:0] lo;
        lo = 32'(n) * 32'h9E37_79B9 + 32'h1234_5678;
        return {4'(n), lo};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit fw, input int af, input int ae);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        cfg_fwft = fw;
        cfg_af_off = PW'(af);
        cfg_ae_off = PW'(ae);
        fwft_m = fw;
        af_m = af;
        ae_m = ae;
        repeat (5) @(negedge wclk);
        rst_n = 1'b1;
        @(negedge wclk);
    endtask

    task automatic settle();
        repeat (6) @(negedge wclk);
    endtask

    task automatic push(input logic [W-1:0] d);
        @(negedge wclk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    // Standard read: one request, data captured at the following negedge.
    task automatic rd_std(output logic [W-1:0] d);
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Expected flags for n words held as seen by the user (R3, R4, R6, R7).
    task automatic check_flags(input int n);
        int memw;
        memw = fwft_m ? ((n > 0) ? n - 1 : 0) : n;
        if (fwft_m) begin
            chk($sformatf("R4 wr_flag n=%0d", n), W'(wr_flag), W'(memw < D));
            chk($sformatf("R4 rd_flag n=%0d", n), W'(rd_flag), W'(n > 0));
        end else begin
            chk($sformatf("R3 wr_flag n=%0d", n), W'(wr_flag), W'(memw == D));
            chk($sformatf("R3 rd_flag n=%0d", n), W'(rd_flag), W'(n == 0));
        end
        chk($sformatf("R6 almost_empty n=%0d", n), W'(rd_almost_empty), W'(n <= ae_m));
        chk($sformatf("R7 almost_full n=%0d", n), W'(wr_almost_full), W'((D - memw) <= af_m));
    endtask

    task automatic stream(input bit fw);
        int got;
        use_async = 1'b1;
        do_reset(fw, 4, 4);
        got = 0;
        fork
            begin : writer
                int k;
                k = 0;
                while (k < NSTREAM) begin
                    @(negedge wclk);
                    if (fw ? wr_flag : !wr_flag) begin
                        wr_en = 1'b1;
                        wr_data = word(3000 + k);
                        k++;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin : reader
                while (got < NSTREAM) begin
                    if (fw) begin
                        @(negedge rclk);
                        if (rd_flag) begin
                            chk($sformatf("R1 async fwft word %0d", got), rd_data, word(3000 + got));
                            rd_en = 1'b1;
                            got++;
                        end else begin
                            rd_en = 1'b0;
                        end
                    end else begin
                        @(negedge rclk);
                        if (!rd_flag) begin
                            logic [W-1:0] d;
                            rd_en = 1'b1;
                            @(negedge rclk);
                            rd_en = 1'b0;
                            d = rd_data;
                            chk($sformatf("R1 async std word %0d", got), d, word(3000 + got));
                            got++;
                        end
                    end
                end
                @(negedge rclk);
                rd_en = 1'b0;
            end
        join
        repeat (8) @(negedge rclk);
        chk("R1 async stream drained", W'(fw ? rd_flag : !rd_flag), W'(0));
        use_async = 1'b0;
    endtask

    initial begin : watchdog
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [W-1:0] d;

        // ---------- standard timing: reset, sweep up, overflow, sweep down ----------
        do_reset(1'b0, 5, 3);
        chk("R2 std wr_flag after reset", W'(wr_flag), W'(0));
        chk("R2 std rd_flag after reset", W'(rd_flag), W'(1));
        chk("R2 std almost_empty after reset", W'(rd_almost_empty), W'(1));
        chk("R2 rd_data cleared", rd_data, '0);
        // R9: change configuration after reset; behaviour must follow the captured values.
        cfg_fwft = 1'b1;
        cfg_af_off = PW'(200);
        cfg_ae_off = PW'(200);
        rd_std(d);
        settle();
        chk("R5 read at empty keeps rd_data", d, '0);
        chk("R5 read at empty stays empty", W'(rd_flag), W'(1));
        for (int n = 1; n <= D; n++) begin
            push(word(n));
            settle();
            check_flags(n);
            if (n == 10) chk("R9 ae offset held after reset", W'(rd_almost_empty), W'(0));
        end
        push(word(9999));
        settle();
        chk("R5 write at full stays full", W'(wr_flag), W'(1));
        for (int i = 1; i <= D; i++) begin
            rd_std(d);
            chk($sformatf("R1 std order word %0d", i), d, word(i));
            if (i == 1) chk("R3 std read updates rd_data", d, word(1));
            settle();
            check_flags(D - i);
        end
        rd_std(d);
        settle();
        chk("R5 dropped word never appears", d, word(D));
        chk("R5 empty after drain", W'(rd_flag), W'(1));

        // ---------- same-edge read and write ----------
        do_reset(1'b0, 2, 2);
        for (int k = 0; k < 4; k++) push(word(500 + k));
        settle();
        for (int i = 0; i <= 40; i++) begin
            @(negedge wclk);
            if (i > 0)
                chk($sformatf("R8 concurrent read %0d", i - 1), rd_data,
                    (i - 1 < 4) ? word(500 + i - 1) : word(1000 + i - 1 - 4));
            if (i < 40) begin
                wr_en = 1'b1;
                wr_data = word(1000 + i);
                rd_en = 1'b1;
            end else begin
                wr_en = 1'b0;
                rd_en = 1'b0;
            end
        end
        settle();
        check_flags(4);
        for (int k = 0; k < 4; k++) begin
            rd_std(d);
            chk($sformatf("R8 remaining word %0d", k), d, word(1000 + 36 + k));
        end
        settle();
        check_flags(0);

        // ---------- fall-through timing ----------
        do_reset(1'b1, 5, 3);
        chk("R2 fwft wr_flag after reset", W'(wr_flag), W'(1));
        chk("R2 fwft rd_flag after reset", W'(rd_flag), W'(0));
        cfg_fwft = 1'b0;
        for (int n = 1; n <= D + 1; n++) begin
            push(word(n));
            settle();
            check_flags(n);
            if (n == 1) begin
                chk("R4 first word shown without read", rd_data, word(1));
                chk("R9 mode held after reset", W'(rd_flag), W'(1));
            end
        end
        push(word(8888));
        settle();
        chk("R5 fwft write when not ready ignored", W'(wr_flag), W'(0));
        for (int i = 1; i <= D + 1; i++) begin
            chk($sformatf("R4 fwft ready before read %0d", i), W'(rd_flag), W'(1));
            chk($sformatf("R1 fwft order word %0d", i), rd_data, word(i));
            @(negedge rclk);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
            settle();
            check_flags(D + 1 - i);
        end
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        settle();
        chk("R5 fwft read when not ready ignored", W'(rd_flag), W'(0));
        push(word(4242));
        settle();
        chk("R5 next word after ignored read", rd_data, word(4242));
        chk("R4 ready after refill", W'(rd_flag), W'(1));

        // ---------- unrelated clocks ----------
        stream(1'b0);
        stream(1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule